// File: doc/BRIEF.md
# Load/Store Sub-Word Data Aligner

This block sits between a 32-bit register file and a byte-addressed, 32-bit, little-endian data memory port. For each memory operation it forms the effective address, chooses the byte lanes the access touches, and spreads the store value across those lanes. For loads it also takes the word read from memory, picks out the addressed byte or halfword, and sign- or zero-extends it into a 32-bit result. An access whose address does not suit its size is flagged, and the flag also stops any write.

Requests enter on a valid/ready stream that carries the opcode, the base register, the 16-bit displacement, the store register and the memory read word. Results leave on a second valid/ready stream through one register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so the block can accept one request every cycle. When `out_valid` is high and `out_ready` is low, the output holds all its fields unchanged and stops accepting input. Once the producer raises `in_valid`, it keeps the request steady until it is taken.

Top module: `lsa_aligner`

## Requirements
- R1: `out_addr` equals `in_base` plus `in_imm` sign-extended to 32 bits, modulo 2^32. With a zero base the address is the sign-extended displacement. With a zero displacement the address is the base.
- R2: `out_be` bit k enables memory bits [8k+7:8k], where lane = address[1:0]. A byte access gives 4'b0001 << lane. A halfword access gives 4'b0011 << lane. A word access gives 4'b1111. A misaligned access or an unknown opcode gives 4'b0000.
- R3: For stores, `out_wdata` repeats the low byte of `in_store` in all four lanes (byte store) or repeats its low halfword in both halves (halfword store). A word store passes `in_store` through unchanged. For any opcode that is not a store, `out_wdata` is zero.
- R4: For aligned loads, `out_ldata` holds the byte at memory bits [8*lane+7:8*lane] or the halfword at bits [16*address[1]+15:16*address[1]]. This value is sign-extended for signed loads and zero-extended for unsigned loads. A word load returns the whole read word.
- R5: A halfword access with address[0]=1, or a word access with address[1:0]≠0, sets `out_misalign`. It also forces `out_wr` to 0, `out_be` to 0 and `out_ldata` to 0. Byte accesses never set the flag.
- R6: Opcodes are decoded as follows: 0x20 is a signed byte load, 0x21 a signed halfword load, 0x23 a word load, 0x24 an unsigned byte load and 0x25 an unsigned halfword load. 0x28 is a byte store, 0x29 a halfword store and 0x2b a word store. `out_ld` is 1 for every load opcode. `out_wr` is 1 only for an aligned store. Any other opcode gives `out_ld`=0, `out_wr`=0, `out_misalign`=0 and `out_ldata`=0.
- R7: A request taken at an edge appears with `out_valid`=1 after that edge. `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, every output field holds steady.
- R8: While `rst_n` is low and after it is released, `out_valid` is 0 and `in_ready` is 1 until the first request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 6 | Operation code |
| in_base | input | 32 | Base register value |
| in_imm | input | 16 | Signed displacement |
| in_store | input | 32 | Store register value |
| in_rdword | input | 32 | Word read from memory at the aligned address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Effective byte address |
| out_be | output | 4 | Byte-lane enables |
| out_wdata | output | 32 | Lane-replicated store data |
| out_wr | output | 1 | Write permitted |
| out_ld | output | 1 | Operation is a load |
| out_ldata | output | 32 | Extended load result |
| out_misalign | output | 1 | Address does not suit the access size |

## Verification
Two functions can land in the same cycle. The first case is a new request being taken while the previous result drains: the bench raises `out_ready` and `in_valid` together in long random runs and checks that a result appears on the very next cycle with no gap. The second case is a store that is also misaligned: directed halfword and word stores at every lane offset check, in the same result, that the flag rises, `out_wr` drops and the byte enables clear. A behavioural queue model predicts every field, and the results are compared on every clock, including cycles where the output is held under back-pressure.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LDB_S = 6'h20;
  localparam logic [OPC_W-1:0] OPC_LDH_S = 6'h21;
  localparam logic [OPC_W-1:0] OPC_LDW   = 6'h23;
  localparam logic [OPC_W-1:0] OPC_LDB_U = 6'h24;
  localparam logic [OPC_W-1:0] OPC_LDH_U = 6'h25;
  localparam logic [OPC_W-1:0] OPC_STB   = 6'h28;
  localparam logic [OPC_W-1:0] OPC_STH   = 6'h29;
  localparam logic [OPC_W-1:0] OPC_STW   = 6'h2b;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    acc_size_e size;
    logic      load;
    logic      store;
    logic      sext;
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic [OPC_W-1:0] op);
    acc_kind_t k;
    k = '{size: SZ_NONE, load: 1'b0, store: 1'b0, sext: 1'b0};
    case (op)
      OPC_LDB_S: k = '{size: SZ_BYTE, load: 1'b1, store: 1'b0, sext: 1'b1};
      OPC_LDH_S: k = '{size: SZ_HALF, load: 1'b1, store: 1'b0, sext: 1'b1};
      OPC_LDW:   k = '{size: SZ_WORD, load: 1'b1, store: 1'b0, sext: 1'b0};
      OPC_LDB_U: k = '{size: SZ_BYTE, load: 1'b1, store: 1'b0, sext: 1'b0};
      OPC_LDH_U: k = '{size: SZ_HALF, load: 1'b1, store: 1'b0, sext: 1'b0};
      OPC_STB:   k = '{size: SZ_BYTE, load: 1'b0, store: 1'b1, sext: 1'b0};
      OPC_STH:   k = '{size: SZ_HALF, load: 1'b0, store: 1'b1, sext: 1'b0};
      OPC_STW:   k = '{size: SZ_WORD, load: 1'b0, store: 1'b1, sext: 1'b0};
      default:   ;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IMM_W     = 16,
  parameter int LANE_BITS = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              misalign
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] disp;
  assign disp = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign ea   = base + disp;

  always_comb begin
    case (size)
      SZ_HALF: misalign = ea[0];
      SZ_WORD: misalign = |ea[LANE_BITS-1:0];
      default: misalign = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LANE_BITS = 2
) (
  input  acc_size_e               size,
  input  logic [LANE_BITS-1:0]    lane,
  input  logic [DATA_W-1:0]       st,
  output logic [DATA_W/8-1:0]     be,
  output logic [DATA_W-1:0]       wdata
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LANE_BITS-1:0] IDX = LANE_BITS'(i);
    logic       lane_en;
    logic [7:0] lane_byte;

    always_comb begin
      case (size)
        SZ_BYTE: begin
          lane_en   = (lane == IDX);
          lane_byte = st[7:0];
        end
        SZ_HALF: begin
          lane_en   = (lane[LANE_BITS-1:1] == IDX[LANE_BITS-1:1]);
          lane_byte = st[8*(i%2) +: 8];
        end
        SZ_WORD: begin
          lane_en   = 1'b1;
          lane_byte = st[8*i +: 8];
        end
        default: begin
          lane_en   = 1'b0;
          lane_byte = 8'h00;
        end
      endcase
    end

    assign be[i]           = lane_en;
    assign wdata[8*i +: 8] = lane_byte;
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LANE_BITS = 2
) (
  input  acc_size_e            size,
  input  logic                 sext,
  input  logic [LANE_BITS-1:0] lane,
  input  logic [DATA_W-1:0]    rd,
  output logic [DATA_W-1:0]    ldata
);
  localparam int LANES = DATA_W / 8;
  localparam int HALVES = LANES / 2;

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = 8'h00;
    for (int k = 0; k < LANES; k++) begin
      if (lane == LANE_BITS'(k)) sel_b = rd[8*k +: 8];
    end
  end

  always_comb begin
    sel_h = 16'h0000;
    for (int k = 0; k < HALVES; k++) begin
      if (lane[LANE_BITS-1:1] == (LANE_BITS-1)'(k)) sel_h = rd[16*k +: 16];
    end
  end

  always_comb begin
    case (size)
      SZ_BYTE: ldata = {{(DATA_W-8){sext & sel_b[7]}}, sel_b};
      SZ_HALF: ldata = {{(DATA_W-16){sext & sel_h[15]}}, sel_h};
      SZ_WORD: ldata = rd;
      default: ldata = '0;
    endcase
  end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [lsa_pkg::OPC_W-1:0] in_op,
  input  logic [ADDR_W-1:0]       in_base,
  input  logic [IMM_W-1:0]        in_imm,
  input  logic [DATA_W-1:0]       in_store,
  input  logic [DATA_W-1:0]       in_rdword,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [DATA_W/8-1:0]     out_be,
  output logic [DATA_W-1:0]       out_wdata,
  output logic                    out_wr,
  output logic                    out_ld,
  output logic [DATA_W-1:0]       out_ldata,
  output logic                    out_misalign
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  acc_kind_t             kind;
  logic [ADDR_W-1:0]     ea;
  logic                  mis;
  logic [LANES-1:0]      be_raw;
  logic [DATA_W-1:0]     wdata_raw;
  logic [DATA_W-1:0]     ldata_raw;
  logic                  take;

  assign kind = classify(in_op);

  lsa_addr_gen #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .LANE_BITS(LANE_BITS)
  ) u_addr (
    .base(in_base), .imm(in_imm), .size(kind.size), .ea(ea), .misalign(mis)
  );

  lsa_store_lane #(
    .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
  ) u_store (
    .size(kind.size), .lane(ea[LANE_BITS-1:0]), .st(in_store),
    .be(be_raw), .wdata(wdata_raw)
  );

  lsa_load_extract #(
    .DATA_W(DATA_W), .LANE_BITS(LANE_BITS)
  ) u_load (
    .size(kind.size), .sext(kind.sext), .lane(ea[LANE_BITS-1:0]),
    .rd(in_rdword), .ldata(ldata_raw)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_be       <= '0;
      out_wdata    <= '0;
      out_wr       <= 1'b0;
      out_ld       <= 1'b0;
      out_ldata    <= '0;
      out_misalign <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_addr     <= ea;
      out_be       <= mis ? '0 : be_raw;
      out_wdata    <= kind.store ? wdata_raw : '0;
      out_wr       <= kind.store && !mis;
      out_ld       <= kind.load;
      out_ldata    <= (kind.load && !mis) ? ldata_raw : '0;
      out_misalign <= mis;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // Output register stage: back-pressure and acceptance
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_be)
      && $stable(out_wdata) && $stable(out_ldata) && $stable(out_wr));

  assert_accept_shows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // Misalignment gating across the lane and address logic
  assert_misalign_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> !out_wr && (out_be == '0) && (out_ldata == '0));

  // Lane enable shapes produced by the store lane unit
  assert_be_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr |-> ($countones(out_be) == 1) || (out_be == 4'b0011)
      || (out_be == 4'b1100) || (out_be == 4'b1111));

  // Decode: a result is never both a load and a write
  assert_ld_wr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_wr && out_ld));
endmodule

// File: tb/tb_lsa_aligner.sv
module tb_lsa_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_op = '0;
  logic [31:0] in_base = '0;
  logic [15:0] in_imm = '0;
  logic [31:0] in_store = '0;
  logic [31:0] in_rdword = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [3:0]  out_be;
  logic [31:0] out_wdata;
  logic        out_wr;
  logic        out_ld;
  logic [31:0] out_ldata;
  logic        out_misalign;

  always #2.5 clk = ~clk;

  lsa_aligner dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_base(in_base), .in_imm(in_imm), .in_store(in_store),
    .in_rdword(in_rdword), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_be(out_be), .out_wdata(out_wdata), .out_wr(out_wr),
    .out_ld(out_ld), .out_ldata(out_ldata), .out_misalign(out_misalign)
  );

  typedef struct {
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        wr;
    logic        ld;
    logic [31:0] ldata;
    logic        mis;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail = 0;
  bit   finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [5:0] op, input logic [31:0] base,
                                 input logic [15:0] imm, input logic [31:0] st,
                                 input logic [31:0] rd);
    exp_t e;
    int size;  // 0 none, 1 byte, 2 half, 4 word
    bit is_ld, is_st, signed_ld;
    int lane;
    logic [31:0] b, h;
    size = 0; is_ld = 0; is_st = 0; signed_ld = 0;
    case (op)
      6'h20: begin size = 1; is_ld = 1; signed_ld = 1; end
      6'h21: begin size = 2; is_ld = 1; signed_ld = 1; end
      6'h23: begin size = 4; is_ld = 1; end
      6'h24: begin size = 1; is_ld = 1; end
      6'h25: begin size = 2; is_ld = 1; end
      6'h28: begin size = 1; is_st = 1; end
      6'h29: begin size = 2; is_st = 1; end
      6'h2b: begin size = 4; is_st = 1; end
      default: ;
    endcase
    e.addr = base + {{16{imm[15]}}, imm};
    lane = int'(e.addr % 4);
    e.mis = (size != 0) && ((e.addr % size) != 0);
    e.ld = is_ld;
    e.wr = is_st && !e.mis;
    if (size == 0 || e.mis) e.be = 4'b0000;
    else if (size == 1) e.be = 4'b0001 << lane;
    else if (size == 2) e.be = 4'b0011 << lane;
    else e.be = 4'b1111;
    if (!is_st) e.wdata = 32'h0;
    else if (size == 1) e.wdata = {4{st[7:0]}};
    else if (size == 2) e.wdata = {2{st[15:0]}};
    else e.wdata = st;
    b = (rd >> (8 * lane)) & 32'hFF;
    h = (rd >> (8 * lane)) & 32'hFFFF;
    if (!is_ld || e.mis) e.ldata = 32'h0;
    else if (size == 1) e.ldata = (signed_ld && b[7]) ? (b | 32'hFFFF_FF00) : b;
    else if (size == 2) e.ldata = (signed_ld && h[15]) ? (h | 32'hFFFF_0000) : h;
    else e.ldata = rd;
    return e;
  endfunction

  // Compare outputs away from the edge, then drive the next cycle and advance the model.
  task automatic step(input bit v, input bit rdy, input logic [5:0] op,
                      input logic [31:0] base, input logic [15:0] imm,
                      input logic [31:0] st, input logic [31:0] rd);
    bit exp_ready;
    chk("R7 out_valid", {31'b0, out_valid}, {31'b0, q.size() != 0});
    if (q.size() != 0 && out_valid) begin
      chk("R1 addr", out_addr, q[0].addr);
      chk("R2 be", {28'b0, out_be}, {28'b0, q[0].be});
      chk("R3 wdata", out_wdata, q[0].wdata);
      chk("R4 ldata", out_ldata, q[0].ldata);
      chk("R5 misalign", {31'b0, out_misalign}, {31'b0, q[0].mis});
      chk("R6 wr", {31'b0, out_wr}, {31'b0, q[0].wr});
      chk("R6 ld", {31'b0, out_ld}, {31'b0, q[0].ld});
    end
    in_valid = v; out_ready = rdy; in_op = op; in_base = base;
    in_imm = imm; in_store = st; in_rdword = rd;
    #1;
    exp_ready = (q.size() == 0) || rdy;
    chk("R7 in_ready", {31'b0, in_ready}, {31'b0, exp_ready});
    if (q.size() != 0 && rdy) void'(q.pop_front());
    if (v && exp_ready) q.push_back(model(op, base, imm, st, rd));
    @(negedge clk);
  endtask

  logic [5:0] ops [9] = '{6'h20, 6'h21, 6'h23, 6'h24, 6'h25, 6'h28, 6'h29, 6'h2b, 6'h22};

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 out_valid in reset", {31'b0, out_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_valid after reset", {31'b0, out_valid}, 32'h0);
    chk("R8 in_ready after reset", {31'b0, in_ready}, 32'h1);

    // Every opcode (plus one unknown) at every lane offset, back to back
    for (int o = 0; o < 9; o++)
      for (int off = 0; off < 4; off++)
        step(1, 1, ops[o], 32'h0000_1000, 16'(off), 32'hA5C3_96E1, 32'h80F1_7F82);

    // R1 absolute and register-indirect forms, negative displacement
    step(1, 1, 6'h23, 32'h0, 16'hFFFC, 32'h1, 32'hDEAD_BEEF);
    step(1, 1, 6'h28, 32'h2000_0003, 16'h0, 32'h0000_0077, 32'h0);
    step(1, 1, 6'h21, 32'h0001_0000, 16'h8000, 32'h0, 32'h1234_8765);
    step(1, 1, 6'h2b, 32'hFFFF_FFFF, 16'h0001, 32'hCAFE_F00D, 32'h0);

    // R7: hold under back-pressure, then drain while taking new data
    step(1, 0, 6'h29, 32'h0000_0102, 16'h0, 32'h0000_BEEF, 32'h0);
    for (int i = 0; i < 4; i++) step(1, 0, 6'h20, 32'h0, 16'h0, 32'h0, 32'h0);
    step(0, 1, 6'h0, 32'h0, 16'h0, 32'h0, 32'h0);
    step(0, 1, 6'h0, 32'h0, 16'h0, 32'h0, 32'h0);

    // Random traffic with random valid/ready
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op;
      op = ($urandom_range(0, 7) == 0) ? 6'($urandom) : ops[$urandom_range(0, 8)];
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, op, $urandom,
           16'($urandom), $urandom, $urandom);
    end
    step(0, 1, 6'h0, 32'h0, 16'h0, 32'h0, 32'h0);
    step(0, 1, 6'h0, 32'h0, 16'h0, 32'h0, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule